// File: doc/BRIEF.md
# Status Register Write-Protect Controller

This block holds the status byte of a serial nonvolatile memory and decides whether each pending status write or array write may proceed. The serial front end has already decoded the incoming instruction and end of frame. It presents one-cycle command strobes: write enable, status write with its data byte, array write commit with its target address, and write done from the programming engine. The block answers every status or array commit with a one-cycle allow or deny verdict. It also drives the status byte continuously for readback.

Protection has three layers. First, a write enable latch must be armed by a write enable instruction framed with exactly eight bits. Second, a two-bit lock field guards the top quarter, the top half or the whole array. Third, a protect-enable bit combines with the external write-protect pin. When protect-enable is 1 and the pin is low, the status byte is frozen, and the pin must be raised before status changes are accepted again. This lets a factory program the lock field with the pin tied low, then set protect-enable as a final one-time lock.

All interfaces are plain level or strobe pins. There is no data stream, so no valid/ready handshake and no back-pressure. The front end must present at most one of the four strobes in any cycle.

Top module: `sr_guard`

## Requirements
- R1: After power-on reset the status byte reads 0x00 and no verdict output is high.
- R2: The write enable latch (status bit 1) is set by a write enable strobe only when `wren_clean` is 1. An unclean write enable leaves it unchanged.
- R3: A status or array commit made while the latch is 0 is denied, and neither the latch nor the write-in-progress bit (status bit 0) changes.
- R4: With protect-enable (status bit 7) at 0, a status write with the latch set is accepted at either pin level. It loads data bit 7 into bit 7 and data bits 3:2 into the lock field (status bits 3:2). All other data bits are ignored and bits 6:4 read 0.
- R5: With protect-enable at 1 and `wp_pin` low, a status write is denied, the status byte keeps its protection bits and the latch is cleared. With the pin high, the write is accepted.
- R6: An array write is denied and clears the latch when its address falls in the locked region. Lock code 0 locks nothing, 1 locks the top quarter of the address space, 2 the top half, and 3 everything. Outside the region the write is accepted.
- R7: An accepted commit sets the write-in-progress bit in the cycle after its strobe. A write done strobe clears both the write-in-progress bit and the latch in the next cycle.
- R8: A commit made while a write is in progress is denied and leaves the latch and the protection bits unchanged.
- R9: A synchronous soft reset clears the latch and the write-in-progress bit but keeps protect-enable and the lock field. Only power-on reset clears those two.
- R10: Every status or array commit produces exactly one verdict pulse (allow or deny, on the matching target's outputs), one cycle wide, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| wp_pin | input | 1 | External write-protect pin level |
| cmd_wren | input | 1 | Write enable instruction strobe |
| wren_clean | input | 1 | Chip select rose after exactly eight bits of the write enable |
| cmd_wrsr | input | 1 | Status write commit strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_wrar | input | 1 | Array write commit strobe |
| wrar_addr | input | AW | Target address of the array write |
| wr_done | input | 1 | Nonvolatile write completed strobe |
| status_out | output | 8 | Status byte for readback |
| sr_allow | output | 1 | Status write allowed pulse |
| sr_deny | output | 1 | Status write denied pulse |
| ar_allow | output | 1 | Array write allowed pulse |
| ar_deny | output | 1 | Array write denied pulse |

## Verification
The hardest state to reach is the locked mode, where protect-enable is 1 and the pin is low. Getting there requires a status write that sets protect-enable while the pin is low. After that, the same sequence with the pin still low must be refused, and the pin must be raised before the lock can be cleared. The stimulus walks this path in order and checks that a soft reset issued while locked does not release the lock. For the array regions, the bench loads each lock code in turn through accepted status writes. It then probes addresses on both sides of each boundary.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  typedef enum logic [1:0] {
    LOCK_NONE = 2'd0,
    LOCK_QTR  = 2'd1,
    LOCK_HALF = 2'd2,
    LOCK_ALL  = 2'd3
  } lock_e;

  localparam int BIT_WIP  = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_LKLO = 2;
  localparam int BIT_PEN  = 7;

  localparam int N_TGT   = 2;
  localparam int TGT_SR  = 0;
  localparam int TGT_AR  = 1;
endpackage

// File: rtl/sr_guard_zone.sv
module sr_guard_zone
  import sr_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input  lock_e         lock,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int TOP = AW - 1;

  always_comb begin
    unique case (lock)
      LOCK_NONE: hit = 1'b0;
      LOCK_QTR:  hit = addr[TOP] & addr[TOP-1];
      LOCK_HALF: hit = addr[TOP];
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_guard_nv.sv
module sr_guard_nv
  import sr_guard_pkg::*;
(
  input  logic  clk,
  input  logic  por_n,
  input  logic  load,
  input  logic  pen_in,
  input  lock_e lock_in,
  output logic  pen,
  output lock_e lock
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pen  <= 1'b0;
      lock <= LOCK_NONE;
    end else if (load) begin
      pen  <= pen_in;
      lock <= lock_in;
    end
  end
endmodule

// File: rtl/sr_guard_ctl.sv
module sr_guard_ctl
  import sr_guard_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             soft_rst,
  input  logic             cmd_wren,
  input  logic             wren_clean,
  input  logic             wr_done,
  input  logic [N_TGT-1:0] req,
  input  logic [N_TGT-1:0] ok,
  output logic             wel,
  output logic             wip,
  output logic [N_TGT-1:0] allow,
  output logic [N_TGT-1:0] deny,
  output logic [N_TGT-1:0] go
);
  logic [N_TGT-1:0] blocked;
  logic             eligible;

  assign eligible = wel & ~wip & ~soft_rst;

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    assign go[t]      = req[t] & eligible & ok[t];
    assign blocked[t] = req[t] & eligible & ~ok[t];

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        allow[t] <= 1'b0;
        deny[t]  <= 1'b0;
      end else if (soft_rst) begin
        allow[t] <= 1'b0;
        deny[t]  <= 1'b0;
      end else begin
        allow[t] <= go[t];
        deny[t]  <= req[t] & ~go[t];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wel <= 1'b0;
      wip <= 1'b0;
    end else if (soft_rst) begin
      wel <= 1'b0;
      wip <= 1'b0;
    end else if (wr_done) begin
      wel <= 1'b0;
      wip <= 1'b0;
    end else begin
      if (cmd_wren && wren_clean) wel <= 1'b1;
      else if (|blocked)          wel <= 1'b0;
      if (|go)                    wip <= 1'b1;
    end
  end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          soft_rst,
  input  logic          wp_pin,
  input  logic          cmd_wren,
  input  logic          wren_clean,
  input  logic          cmd_wrsr,
  input  logic [7:0]    wrsr_data,
  input  logic          cmd_wrar,
  input  logic [AW-1:0] wrar_addr,
  input  logic          wr_done,
  output logic [7:0]    status_out,
  output logic          sr_allow,
  output logic          sr_deny,
  output logic          ar_allow,
  output logic          ar_deny
);
  logic             pen;
  lock_e            lock;
  logic             wel;
  logic             wip;
  logic             zone_hit;
  logic [N_TGT-1:0] req;
  logic [N_TGT-1:0] ok;
  logic [N_TGT-1:0] allow;
  logic [N_TGT-1:0] deny;
  logic [N_TGT-1:0] go;

  assign req[TGT_SR] = cmd_wrsr;
  assign req[TGT_AR] = cmd_wrar;
  assign ok[TGT_SR]  = ~(pen & ~wp_pin);
  assign ok[TGT_AR]  = ~zone_hit;

  sr_guard_zone #(.AW(AW)) u_zone (
    .lock (lock),
    .addr (wrar_addr),
    .hit  (zone_hit)
  );

  sr_guard_nv u_nv (
    .clk     (clk),
    .por_n   (por_n),
    .load    (go[TGT_SR]),
    .pen_in  (wrsr_data[BIT_PEN]),
    .lock_in (lock_e'(wrsr_data[BIT_LKLO+1:BIT_LKLO])),
    .pen     (pen),
    .lock    (lock)
  );

  sr_guard_ctl u_ctl (
    .clk        (clk),
    .por_n      (por_n),
    .soft_rst   (soft_rst),
    .cmd_wren   (cmd_wren),
    .wren_clean (wren_clean),
    .wr_done    (wr_done),
    .req        (req),
    .ok         (ok),
    .wel        (wel),
    .wip        (wip),
    .allow      (allow),
    .deny       (deny),
    .go         (go)
  );

  always_comb begin
    status_out                        = '0;
    status_out[BIT_WIP]               = wip;
    status_out[BIT_WEL]               = wel;
    status_out[BIT_LKLO+1:BIT_LKLO]   = lock;
    status_out[BIT_PEN]               = pen;
  end

  assign sr_allow = allow[TGT_SR];
  assign sr_deny  = deny[TGT_SR];
  assign ar_allow = allow[TGT_AR];
  assign ar_deny  = deny[TGT_AR];
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       por_n,
  input logic       soft_rst,
  input logic       wp_pin,
  input logic       cmd_wren,
  input logic       wren_clean,
  input logic       cmd_wrsr,
  input logic       cmd_wrar,
  input logic       wr_done,
  input logic [7:0] status_out,
  input logic       sr_allow,
  input logic       sr_deny,
  input logic       ar_allow,
  input logic       ar_deny
);
  AST_WEL_FROM_WREN: assert property (@(posedge clk) disable iff (!por_n)
    $rose(status_out[1]) |-> $past(cmd_wren && wren_clean)); // R2

  AST_NO_WEL_DENY: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_wrsr || cmd_wrar) && !status_out[1] && !soft_rst
      |=> (sr_deny || ar_deny) && !status_out[0]); // R3

  AST_LOCKED_SR: assert property (@(posedge clk) disable iff (!por_n)
    cmd_wrsr && status_out[7] && !wp_pin && !status_out[0] && !soft_rst
      |=> sr_deny && !status_out[1] && status_out[7]); // R5

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    wr_done && !soft_rst |=> !status_out[0] && !status_out[1]); // R7

  AST_BUSY_DENY: assert property (@(posedge clk) disable iff (!por_n)
    cmd_wrar && status_out[0] && !soft_rst |=> ar_deny && status_out[1]); // R8

  AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    soft_rst |=> $stable(status_out[7]) && $stable(status_out[3:2])); // R9

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({sr_allow, sr_deny, ar_allow, ar_deny})); // R10

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!por_n)
    status_out[6:4] == 3'b000); // R4
endmodule

bind sr_guard sr_guard_chk u_chk (.*);

// File: tb/sim_sr_guard.sv
module sim_sr_guard;
  localparam int AW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          soft_rst = 1'b0;
  logic          wp_pin = 1'b0;
  logic          cmd_wren = 1'b0;
  logic          wren_clean = 1'b0;
  logic          cmd_wrsr = 1'b0;
  logic [7:0]    wrsr_data = '0;
  logic          cmd_wrar = 1'b0;
  logic [AW-1:0] wrar_addr = '0;
  logic          wr_done = 1'b0;
  logic [7:0]    status_out;
  logic          sr_allow, sr_deny, ar_allow, ar_deny;

  always #10 clk = ~clk;

  sr_guard #(.AW(AW)) u0 (.*);

  int    n_chk = 0;
  int    n_bad = 0;
  string cur = "R1";

  int m_wel = 0, m_wip = 0, m_pen = 0, m_lock = 0;
  int m_sa = 0, m_sd = 0, m_aa = 0, m_ad = 0;

  function automatic bit in_zone(int lock, int addr);
    case (lock)
      0: return 0;
      1: return addr >= (DEPTH / 4) * 3;
      2: return addr >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  function automatic int m_status();
    return m_pen * 128 + m_lock * 4 + m_wel * 2 + m_wip;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    m_sa = 0; m_sd = 0; m_aa = 0; m_ad = 0;
    if (soft_rst) begin
      m_wel = 0; m_wip = 0;
    end else if (wr_done) begin
      m_wel = 0; m_wip = 0;
    end else if (cmd_wren) begin
      if (wren_clean) m_wel = 1;
    end else if (cmd_wrsr) begin
      if (!m_wel || m_wip) m_sd = 1;
      else if (m_pen && !wp_pin) begin m_sd = 1; m_wel = 0; end
      else begin
        m_sa = 1; m_wip = 1;
        m_pen = wrsr_data[7]; m_lock = wrsr_data[3:2];
      end
    end else if (cmd_wrar) begin
      if (!m_wel || m_wip) m_ad = 1;
      else if (in_zone(m_lock, wrar_addr)) begin m_ad = 1; m_wel = 0; end
      else begin m_aa = 1; m_wip = 1; end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(cur, status_out, m_status(), "status");
    check(cur, {sr_allow, sr_deny, ar_allow, ar_deny},
          {m_sa[0], m_sd[0], m_aa[0], m_ad[0]}, "verdicts");
    soft_rst = 0; cmd_wren = 0; wren_clean = 0;
    cmd_wrsr = 0; cmd_wrar = 0; wr_done = 0;
  endtask

  task automatic wren(bit clean);
    cmd_wren = 1; wren_clean = clean; tick();
  endtask

  task automatic wsr(logic [7:0] d);
    cmd_wrsr = 1; wrsr_data = d; tick();
  endtask

  task automatic war(int a);
    cmd_wrar = 1; wrar_addr = a[AW-1:0]; tick();
  endtask

  task automatic done();
    wr_done = 1; tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur = "R1";
    check("R1", status_out, 0, "reset status");
    check("R1", {sr_allow, sr_deny, ar_allow, ar_deny}, 0, "reset verdicts");
    por_n = 1;
    tick();

    cur = "R3";
    wsr(8'h8C);
    check("R3", sr_deny, 1, "status write without latch");
    war(16);
    check("R3", status_out, 0, "array write without latch");

    cur = "R2";
    wren(0);
    check("R2", status_out[1], 0, "unclean enable");
    wren(1);
    check("R2", status_out[1], 1, "clean enable");

    cur = "R4";
    wp_pin = 0;
    wsr(8'hF7);
    check("R4", status_out, 8'h87, "accepted status write, pin low");
    cur = "R7";
    tick();
    done();
    check("R7", status_out, 8'h84, "after done");

    cur = "R5";
    wren(1);
    wsr(8'h00);
    check("R5", sr_deny, 1, "locked deny");
    check("R5", status_out, 8'h84, "locked keeps bits, latch cleared");
    cur = "R9";
    soft_rst = 1; tick();
    check("R9", status_out, 8'h84, "soft reset keeps lock");
    cur = "R5";
    wren(1);
    wsr(8'h00);
    check("R5", status_out, 8'h84, "still locked after soft reset");
    wp_pin = 1;
    wren(1);
    wsr(8'h08);
    check("R5", sr_allow, 1, "pin high unlocks");
    check("R5", status_out, 8'h0B, "new lock half");
    done();

    cur = "R4";
    wp_pin = 0;
    wren(1);
    wsr(8'h7C);
    check("R4", status_out, 8'h0F, "pen 0 accepts with pin low, ignores bits");
    done();

    cur = "R6";
    for (int lk = 0; lk < 4; lk++) begin
      wren(1); wsr(8'(lk * 4)); done();
      for (int k = 0; k < 6; k++) begin
        int a;
        case (k)
          0: a = 0;
          1: a = DEPTH / 2 - 1;
          2: a = DEPTH / 2;
          3: a = (DEPTH / 4) * 3 - 1;
          4: a = (DEPTH / 4) * 3;
          default: a = DEPTH - 1;
        endcase
        wren(1);
        war(a);
        check("R6", ar_deny, int'(in_zone(lk, a)), "region verdict");
        if (ar_allow) done();
      end
    end

    cur = "R8";
    wren(1); wsr(8'h00); done();
    wren(1);
    war(100);
    war(200);
    check("R8", ar_deny, 1, "commit while busy");
    check("R8", status_out, 8'h03, "busy keeps latch");
    wsr(8'h0C);
    check("R8", status_out[3:2], 0, "busy status write no effect");
    done();

    cur = "R9";
    wren(1);
    war(5);
    soft_rst = 1; tick();
    check("R9", status_out, 8'h00, "soft reset clears latch and wip");

    cur = "R10";
    wren(1);
    war(7);
    tick();
    check("R10", {ar_allow, ar_deny}, 0, "pulse one cycle wide");
    done();

    summary();
  end
endmodule